// File: doc/BRIEF.md
# Fractional-N Feedback Divider Controller

This block sets the division ratio of a PLL feedback counter. The long-run average ratio is INT + FRAC/MOD. INT is a 16-bit whole part, FRAC a 12-bit numerator and MOD a 12-bit programmable modulus, so MOD need not be a power of two. At every divide-cycle boundary, three cascaded accumulators advance by one step. Each accumulator wraps at MOD. Their carries are mixed into a small signed offset that shapes the quantisation noise. That offset is added to INT to form the ratio for a later divide cycle.

The block also holds the programmable counter that divides the fast feedback clock by the current ratio. It produces one output pulse per divide cycle. The configuration inputs are read only at those pulses. The block checks every configuration it reads against the legal ranges, and the minimum INT depends on which dual-modulus prescaler is selected. A configuration that fails the check raises an error flag and is discarded. In that case the block keeps dithering with the last good configuration. When FRAC is zero and the integer-only flag is set, the block bypasses the dithering and emits INT unchanged.

Top module: `fracn_div_ctrl`

## Requirements
- R1: `div_pulse_o` is high for one clock per divide cycle. The number of clocks from one pulse to the next equals the value `ratio_o` holds during the earlier pulse.
- R2: `ratio_o` changes only in the clock that follows a divide pulse. `ratio_stb_o` is high in exactly that clock and low in every other clock.
- R3: While a legal fractional configuration stays unchanged over K consecutive strobes, let S be the sum of (`ratio_o` − INT) over those strobes. |S·MOD − K·FRAC| is at most 4·MOD.
- R4: Each strobed ratio lies between INT−3 and INT+4, where INT is the active whole part.
- R5: Each boundary step runs three cascaded accumulators.
  - Stage 1 adds FRAC. Each later stage adds the new residue of the stage before it.
  - A stage whose sum is at or above MOD subtracts MOD and carries 1.
  - The ratio is INT + c1 + (c2 − c2') + (c3 − 2·c3' + c3''), where ' marks the value from the previous boundary step.
- R6: When the configuration taken at a boundary has FRAC = 0 and `cfg_int_only_i` = 1, the ratio is exactly INT. All accumulators and delayed carries are also cleared.
- R7: A configuration is legal when all three of these hold:
  - MOD ≥ 2.
  - FRAC < MOD.
  - INT ≥ 23 when `cfg_wide_pre_i` = 0 (4/5 prescaler), or INT ≥ 75 when `cfg_wide_pre_i` = 1 (8/9 prescaler).

  A boundary that reads an illegal configuration sets `cfg_err_o` from the next clock and leaves the active configuration unchanged. A boundary that reads a legal one clears `cfg_err_o`.
- R8: Changes to the configuration inputs between boundaries have no effect, provided the inputs are restored before the next boundary.
- R9: When a boundary takes a legal configuration whose MOD differs from the active MOD, the accumulators and delayed carries restart from zero before the step.
- R10: After reset the outputs are as follows:
  - `div_pulse_o` is high in the first clock.
  - `ratio_o` = 75.
  - `ratio_stb_o` and `cfg_err_o` are low.

  The active configuration after reset is INT 75, FRAC 0, MOD 2, wide prescaler, integer-only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast feedback clock being divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_int_i | input | 16 | Whole part of the ratio |
| cfg_frac_i | input | 12 | Fraction numerator |
| cfg_mod_i | input | 12 | Fraction modulus |
| cfg_wide_pre_i | input | 1 | 1 selects the 8/9 prescaler floor, 0 the 4/5 floor |
| cfg_int_only_i | input | 1 | Integer-only request, honoured when FRAC is zero |
| div_pulse_o | output | 1 | One-clock pulse that ends each divide cycle |
| ratio_o | output | 17 | Ratio for the divide cycle after the next pulse |
| ratio_stb_o | output | 1 | High in the clock where `ratio_o` is refreshed |
| cfg_err_o | output | 1 | Last configuration read was illegal |

## Verification
The hardest state to reach from the ports is the accumulator restart on a MOD change. It only happens when a legal configuration with a new modulus arrives after the cascade has built up non-zero residues and delayed carries. The stimulus therefore runs a fractional setting for several boundaries and then changes only MOD. Random runs also switch modulus and legality at arbitrary phases of the divide cycle. Between boundaries the stimulus briefly drives an illegal setting and removes it again, which shows that only the values present at a boundary are ever read.

// File: rtl/fnd_pkg.sv
package fnd_pkg;
  localparam int INT_W = 16;
  localparam int FRC_W = 12;
  localparam int RAT_W = INT_W + 1;
  localparam int MASH_ORDER = 3;
  localparam int OFF_W = 4;

  typedef logic [INT_W-1:0] int_t;
  typedef logic [FRC_W-1:0] frc_t;
  typedef logic [RAT_W-1:0] rat_t;
  typedef logic signed [OFF_W-1:0] off_t;

  typedef struct packed {
    int_t n_int;
    frc_t n_frac;
    frc_t n_mod;
    logic wide_pre;
    logic int_only;
  } cfg_t;

  // Legal range test; the INT floor follows the prescaler choice.
  function automatic logic cfg_ok(input cfg_t c, input int_t lo_narrow, input int_t lo_wide);
    int_t floor_v;
    floor_v = c.wide_pre ? lo_wide : lo_narrow;
    return (c.n_mod >= frc_t'(2)) && (c.n_frac < c.n_mod) && (c.n_int >= floor_v);
  endfunction

  // One modulo-MOD accumulation: returns {carry, residue}.
  function automatic logic [FRC_W:0] wrap_step(input frc_t base, input frc_t addend, input frc_t modulus);
    logic [FRC_W:0] s;
    s = {1'b0, base} + {1'b0, addend};
    if (s >= {1'b0, modulus}) return {1'b1, FRC_W'(s - {1'b0, modulus})};
    return {1'b0, s[FRC_W-1:0]};
  endfunction

  // Third-order error-feedback mix of the carries.
  function automatic off_t mash_mix(input logic c1, input logic c2, input logic c2_z,
                                    input logic c3, input logic c3_z, input logic c3_zz);
    int t;
    t = int'(c1) + int'(c2) - int'(c2_z) + int'(c3) - 2 * int'(c3_z) + int'(c3_zz);
    return OFF_W'(t);
  endfunction

  function automatic rat_t add_off(input int_t n, input off_t off);
    int t;
    t = int'(n) + int'(off);
    return RAT_W'(t);
  endfunction
endpackage

// File: rtl/fnd_cfg_gate.sv
module fnd_cfg_gate
  import fnd_pkg::*;
#(
  parameter int_t MIN_NARROW = int_t'(23),
  parameter int_t MIN_WIDE   = int_t'(75),
  parameter int_t RESET_INT  = int_t'(75)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take_i,
  input  cfg_t req_i,
  output int_t eff_int_o,
  output frc_t eff_frac_o,
  output frc_t eff_mod_o,
  output logic eff_int_only_o,
  output logic restart_o,
  output int_t act_int_o,
  output frc_t act_mod_o,
  output logic err_o
);
  cfg_t act_q;
  cfg_t eff_w;
  logic legal_w;
  logic err_q;

  assign legal_w   = cfg_ok(req_i, MIN_NARROW, MIN_WIDE);
  assign eff_w     = legal_w ? req_i : act_q;
  assign restart_o = legal_w && (req_i.n_mod != act_q.n_mod);

  assign eff_int_o      = eff_w.n_int;
  assign eff_frac_o     = eff_w.n_frac;
  assign eff_mod_o      = eff_w.n_mod;
  assign eff_int_only_o = eff_w.int_only;
  assign act_int_o      = act_q.n_int;
  assign act_mod_o      = act_q.n_mod;
  assign err_o          = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '{n_int: RESET_INT, n_frac: '0, n_mod: frc_t'(2), wide_pre: 1'b1, int_only: 1'b1};
      err_q <= 1'b0;
    end else if (take_i) begin
      if (legal_w) act_q <= req_i;
      err_q <= !legal_w;
    end
  end
endmodule

// File: rtl/fnd_mash3.sv
module fnd_mash3
  import fnd_pkg::*;
#(
  parameter int_t RESET_INT = int_t'(75)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  input  logic restart_i,
  input  int_t n_int_i,
  input  frc_t n_frac_i,
  input  frc_t n_mod_i,
  input  logic int_only_i,
  output logic bypass_o,
  output rat_t ratio_o,
  output logic stb_o,
  output logic [MASH_ORDER-1:0][FRC_W-1:0] acc_o
);
  logic [MASH_ORDER-1:0] cy_w;
  logic bypass_w;
  logic c2_z_q, c3_z_q, c3_zz_q;
  logic c2_z_w, c3_z_w, c3_zz_w;
  off_t off_w;
  rat_t ratio_q;
  logic stb_q;

  assign bypass_w = (n_frac_i == '0) && int_only_i;
  assign bypass_o = bypass_w;

  for (genvar g = 0; g < MASH_ORDER; g++) begin : g_stage
    frc_t acc_q;
    frc_t base_w;
    frc_t addend_w;
    frc_t res_w;
    logic [FRC_W:0] r_w;
    assign base_w = restart_i ? '0 : acc_q;
    if (g == 0) begin : g_head
      assign addend_w = n_frac_i;
    end else begin : g_tail
      assign addend_w = g_stage[g-1].res_w;
    end
    assign r_w      = wrap_step(base_w, addend_w, n_mod_i);
    assign cy_w[g]  = r_w[FRC_W];
    assign res_w    = r_w[FRC_W-1:0];
    assign acc_o[g] = acc_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else if (step_i) acc_q <= bypass_w ? '0 : res_w;
    end
  end

  assign c2_z_w  = restart_i ? 1'b0 : c2_z_q;
  assign c3_z_w  = restart_i ? 1'b0 : c3_z_q;
  assign c3_zz_w = restart_i ? 1'b0 : c3_zz_q;
  assign off_w   = bypass_w ? '0 : mash_mix(cy_w[0], cy_w[1], c2_z_w, cy_w[2], c3_z_w, c3_zz_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c2_z_q  <= 1'b0;
      c3_z_q  <= 1'b0;
      c3_zz_q <= 1'b0;
      ratio_q <= rat_t'(RESET_INT);
      stb_q   <= 1'b0;
    end else begin
      stb_q <= step_i;
      if (step_i) begin
        c2_z_q  <= bypass_w ? 1'b0 : cy_w[1];
        c3_z_q  <= bypass_w ? 1'b0 : cy_w[2];
        c3_zz_q <= bypass_w ? 1'b0 : c3_z_w;
        ratio_q <= add_off(n_int_i, off_w);
      end
    end
  end

  assign ratio_o = ratio_q;
  assign stb_o   = stb_q;
endmodule

// File: rtl/fnd_prog_cnt.sv
module fnd_prog_cnt
  import fnd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  rat_t load_i,
  output logic wrap_o
);
  rat_t cnt_q;

  assign wrap_o = (cnt_q == RAT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RAT_W'(1);
    else if (wrap_o) cnt_q <= load_i;
    else cnt_q <= cnt_q - RAT_W'(1);
  end
endmodule

// File: rtl/fracn_div_ctrl.sv
module fracn_div_ctrl
  import fnd_pkg::*;
#(
  parameter int_t MIN_NARROW = int_t'(23),
  parameter int_t MIN_WIDE   = int_t'(75),
  parameter int_t RESET_INT  = int_t'(75)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  cfg_int_i,
  input  logic [FRC_W-1:0]  cfg_frac_i,
  input  logic [FRC_W-1:0]  cfg_mod_i,
  input  logic              cfg_wide_pre_i,
  input  logic              cfg_int_only_i,
  output logic              div_pulse_o,
  output logic [RAT_W-1:0]  ratio_o,
  output logic              ratio_stb_o,
  output logic              cfg_err_o
);
  cfg_t req_w;
  logic pulse_w;
  logic restart_w;
  logic bypass_w;
  int_t eff_int_w;
  frc_t eff_frac_w;
  frc_t eff_mod_w;
  logic eff_int_only_w;
  int_t act_int_w;
  frc_t act_mod_w;
  rat_t ratio_w;
  logic stb_w;
  logic err_w;
  logic [MASH_ORDER-1:0][FRC_W-1:0] acc_w;

  assign req_w = '{n_int: cfg_int_i, n_frac: cfg_frac_i, n_mod: cfg_mod_i,
                   wide_pre: cfg_wide_pre_i, int_only: cfg_int_only_i};

  fnd_cfg_gate #(.MIN_NARROW(MIN_NARROW), .MIN_WIDE(MIN_WIDE), .RESET_INT(RESET_INT)) u_gate (
    .clk(clk), .rst_n(rst_n), .take_i(pulse_w), .req_i(req_w),
    .eff_int_o(eff_int_w), .eff_frac_o(eff_frac_w), .eff_mod_o(eff_mod_w),
    .eff_int_only_o(eff_int_only_w), .restart_o(restart_w),
    .act_int_o(act_int_w), .act_mod_o(act_mod_w), .err_o(err_w)
  );

  fnd_mash3 #(.RESET_INT(RESET_INT)) u_mash (
    .clk(clk), .rst_n(rst_n), .step_i(pulse_w), .restart_i(restart_w),
    .n_int_i(eff_int_w), .n_frac_i(eff_frac_w), .n_mod_i(eff_mod_w),
    .int_only_i(eff_int_only_w), .bypass_o(bypass_w),
    .ratio_o(ratio_w), .stb_o(stb_w), .acc_o(acc_w)
  );

  fnd_prog_cnt u_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(ratio_w), .wrap_o(pulse_w)
  );

  assign div_pulse_o = pulse_w;
  assign ratio_o     = ratio_w;
  assign ratio_stb_o = stb_w;
  assign cfg_err_o   = err_w;
endmodule

// File: rtl/fracn_div_ctrl_chk.sv
module fracn_div_ctrl_chk
  import fnd_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic pulse,
  input logic stb,
  input rat_t ratio,
  input logic err,
  input logic restart,
  input logic bypass,
  input int_t eff_int,
  input frc_t eff_frac,
  input int_t act_int,
  input frc_t act_mod,
  input logic [MASH_ORDER-1:0][FRC_W-1:0] acc
);
  // R1: a divide cycle is never shorter than two clocks
  p_pulse_gap_r1: assert property (@(posedge clk) disable iff (!rst_n) pulse |=> !pulse);
  // R2: strobe follows each pulse and only a pulse
  p_stb_follows_r2: assert property (@(posedge clk) disable iff (!rst_n) pulse |=> stb);
  p_stb_source_r2: assert property (@(posedge clk) disable iff (!rst_n) stb |-> $past(pulse));
  p_ratio_hold_r2: assert property (@(posedge clk) disable iff (!rst_n) !stb |-> $stable(ratio));
  // R4: strobed ratio stays in the band around the active whole part
  p_ratio_band_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> (int'(ratio) >= int'(act_int) - 3) && (int'(ratio) <= int'(act_int) + 4));
  // R5: residues stay below the active modulus
  p_acc_head_r5: assert property (@(posedge clk) disable iff (!rst_n) acc[0] < act_mod);
  p_acc_tail_r5: assert property (@(posedge clk) disable iff (!rst_n) acc[MASH_ORDER-1] < act_mod);
  // R6: integer-only steps give exactly INT
  p_int_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && bypass) |=> (ratio == {1'b0, $past(eff_int)}));
  // R7: error flag moves only at a boundary
  p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n) !pulse |=> $stable(err));
  // R9: after a modulus restart the head stage holds just FRAC
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && restart && !bypass) |=> (acc[0] == $past(eff_frac)));
endmodule

bind fracn_div_ctrl fracn_div_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pulse(pulse_w), .stb(stb_w), .ratio(ratio_w),
  .err(err_w), .restart(restart_w), .bypass(bypass_w), .eff_int(eff_int_w),
  .eff_frac(eff_frac_w), .act_int(act_int_w), .act_mod(act_mod_w), .acc(acc_w)
);

// File: tb/fracn_div_ctrl_tb_top.sv
module fracn_div_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cfg_int_i = 16'd100;
  logic [11:0] cfg_frac_i = 12'd0;
  logic [11:0] cfg_mod_i = 12'd2;
  logic cfg_wide_pre_i = 1'b0;
  logic cfg_int_only_i = 1'b1;
  logic div_pulse_o;
  logic [16:0] ratio_o;
  logic ratio_stb_o;
  logic cfg_err_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  fracn_div_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_int_i(cfg_int_i), .cfg_frac_i(cfg_frac_i),
    .cfg_mod_i(cfg_mod_i), .cfg_wide_pre_i(cfg_wide_pre_i), .cfg_int_only_i(cfg_int_only_i),
    .div_pulse_o(div_pulse_o), .ratio_o(ratio_o), .ratio_stb_o(ratio_stb_o), .cfg_err_o(cfg_err_o)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  string cur_req = "R5";

  // bench model of the active configuration and cascade
  int m_int = 75, m_frac = 0, m_mod = 2, m_wide = 1, m_io = 1;
  int m_acc[3] = '{0, 0, 0};
  int m_d2 = 0, m_d3 = 0, m_d33 = 0;
  int exp_ratio = 75, exp_int = 75;
  bit exp_err = 0;
  bit stb_due = 0;
  bit have_last = 0;
  int last_ratio = 0;
  int since = 0;
  int cyc = 0;
  bit avg_on = 0;
  longint sum_off = 0;
  longint n_avg = 0;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit legal_fn(int i, int f, int m, int w);
    int floor_v;
    floor_v = (w != 0) ? 75 : 23;
    return (m >= 2) && (f < m) && (i >= floor_v);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // boundary step of the bench model with the inputs the DUT reads next edge
  task automatic model_step();
    int ei, ef, em, eio, x, off, s;
    bit lg, rs;
    bit c[3];
    lg = legal_fn(int'(cfg_int_i), int'(cfg_frac_i), int'(cfg_mod_i), int'(cfg_wide_pre_i));
    rs = lg && (int'(cfg_mod_i) != m_mod);
    if (lg) begin
      m_int = int'(cfg_int_i); m_frac = int'(cfg_frac_i); m_mod = int'(cfg_mod_i);
      m_wide = int'(cfg_wide_pre_i); m_io = int'(cfg_int_only_i);
    end
    ei = m_int; ef = m_frac; em = m_mod; eio = m_io;
    exp_err = !lg;
    if (ef == 0 && eio != 0) begin
      for (int k = 0; k < 3; k++) m_acc[k] = 0;
      m_d2 = 0; m_d3 = 0; m_d33 = 0;
      off = 0;
    end else begin
      if (rs) begin
        for (int k = 0; k < 3; k++) m_acc[k] = 0;
        m_d2 = 0; m_d3 = 0; m_d33 = 0;
      end
      x = ef;
      for (int k = 0; k < 3; k++) begin
        s = m_acc[k] + x;
        c[k] = (s >= em);
        m_acc[k] = c[k] ? s - em : s;
        x = m_acc[k];
      end
      off = int'(c[0]) + int'(c[1]) - m_d2 + int'(c[2]) - 2 * m_d3 + m_d33;
      m_d33 = m_d3;
      m_d3 = int'(c[2]);
      m_d2 = int'(c[1]);
    end
    exp_int = ei;
    exp_ratio = ei + off;
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      since++;
      if (cyc > WD_LIMIT) begin
        chk(0, "R1", "watchdog expired", cyc, WD_LIMIT);
        finish_run();
      end
      if (stb_due) begin
        chk(ratio_stb_o === 1'b1, "R2", "strobe after pulse", ratio_stb_o, 1);
        chk(int'(ratio_o) == exp_ratio, cur_req, "ratio value", ratio_o, exp_ratio);
        chk((int'(ratio_o) >= exp_int - 3) && (int'(ratio_o) <= exp_int + 4), "R4", "ratio band", ratio_o, exp_int);
        if (avg_on) begin
          sum_off += longint'(int'(ratio_o) - exp_int);
          n_avg++;
        end
      end else begin
        chk(ratio_stb_o === 1'b0, "R2", "strobe idle", ratio_stb_o, 0);
      end
      chk(cfg_err_o === exp_err, "R7", "error flag", cfg_err_o, exp_err);
      if (div_pulse_o) begin
        if (have_last) chk(since == last_ratio, "R1", "divide period", since, last_ratio);
        have_last = 1;
        since = 0;
        last_ratio = int'(ratio_o);
        model_step();
        stb_due = 1;
      end else begin
        stb_due = 0;
      end
    end
  end

  task automatic drive(int i, int f, int m, int w, int io);
    @(posedge clk); #2;
    cfg_int_i = 16'(i); cfg_frac_i = 12'(f); cfg_mod_i = 12'(m);
    cfg_wide_pre_i = w[0]; cfg_int_only_i = io[0];
  endtask

  task automatic wait_pulses(int n);
    for (int i = 0; i < n;) begin
      @(negedge clk);
      if (div_pulse_o) i++;
    end
  endtask

  // R3: long-run average against INT + FRAC/MOD
  task automatic avg_run(int i, int f, int m, int w, int n);
    longint diff;
    drive(i, f, m, w, 0);
    wait_pulses(2);
    @(posedge clk); #2;
    sum_off = 0; n_avg = 0; avg_on = 1;
    wait_pulses(n);
    @(posedge clk); #2;
    avg_on = 0;
    diff = sum_off * m - n_avg * f;
    if (diff < 0) diff = -diff;
    chk(diff <= 4 * m, "R3", "average deviation", diff, 4 * m);
    chk(n_avg == longint'(n), "R3", "strobes in window", n_avg, n);
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd2741);
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(div_pulse_o === 1'b1, "R10", "pulse after reset", div_pulse_o, 1);
    chk(ratio_o === 17'd75, "R10", "reset ratio", ratio_o, 75);
    chk(ratio_stb_o === 1'b0, "R10", "reset strobe", ratio_stb_o, 0);
    chk(cfg_err_o === 1'b0, "R10", "reset error", cfg_err_o, 0);

    cur_req = "R6";
    wait_pulses(6);
    avg_run(100, 1, 3, 0, 60);
    avg_run(300, 4094, 4095, 1, 90);
    avg_run(23, 7, 11, 0, 70);
    drive(300, 0, 4095, 1, 0);
    wait_pulses(6);
    drive(300, 0, 4095, 1, 1);
    wait_pulses(4);
    @(negedge clk);
    chk(ratio_o === 17'd300, "R6", "integer-only ratio", ratio_o, 300);

    cur_req = "R9";
    drive(150, 3, 7, 0, 0);
    wait_pulses(10);
    drive(150, 3, 5, 0, 0);
    wait_pulses(10);

    cur_req = "R7";
    drive(22, 0, 2, 0, 1);  wait_pulses(3);
    drive(23, 0, 2, 0, 1);  wait_pulses(2);
    drive(74, 1, 9, 1, 0);  wait_pulses(3);
    drive(75, 1, 9, 1, 0);  wait_pulses(3);
    drive(80, 5, 5, 0, 0);  wait_pulses(2);
    drive(80, 0, 1, 0, 1);  wait_pulses(2);
    drive(80, 0, 0, 0, 1);  wait_pulses(2);
    drive(80, 2, 9, 0, 0);  wait_pulses(3);

    cur_req = "R8";
    wait_pulses(1);
    drive(10, 9, 0, 1, 1);
    repeat (5) @(posedge clk);
    #2;
    cfg_int_i = 16'd80; cfg_frac_i = 12'd2; cfg_mod_i = 12'd9;
    cfg_wide_pre_i = 1'b0; cfg_int_only_i = 1'b0;
    @(negedge clk);
    chk(cfg_err_o === 1'b0, "R8", "mid-cycle glitch ignored", cfg_err_o, 0);
    wait_pulses(2);
    @(negedge clk);
    chk(cfg_err_o === 1'b0, "R8", "error after glitch", cfg_err_o, 0);

    cur_req = "R5";
    for (int it = 0; it < 260; it++) begin
      int w, i, m, f, io, sel;
      w = int'($urandom % 2);
      i = (w != 0 ? 75 : 23) + int'($urandom % 40);
      m = 2 + int'($urandom % 4094);
      f = ($urandom % 5 == 0) ? 0 : int'($urandom % m);
      io = int'($urandom % 2);
      sel = int'($urandom % 10);
      if (sel == 0) m = int'($urandom % 2);
      else if (sel == 1) f = m + int'($urandom % 8);
      else if (sel == 2) i = (w != 0 ? 75 : 23) - 1 - int'($urandom % 5);
      if (f > 4095) f = 4095;
      if ($urandom % 4 == 0) repeat (int'($urandom % 30)) @(posedge clk);
      drive(i, f, m, w, io);
      wait_pulses(1 + int'($urandom % 3));
    end
    finish_run();
  end
endmodule